// File: doc/BRIEF.md
# Serial Link Power Sequencer

This block is the control state machine on the transmitting end of a serial video link. It brings the link up and takes it down. An active-low power-down pin starts each transition. A lock indication from the clock-multiplying delay line tells the block when the delay line has settled. A line that the far end pulls high tells the block that the receiver has lost word alignment. The outputs enable the delay line, enable the serial driver, raise a timed request that tells the far receiver to shut down, and flag when parallel data may be accepted.

The pin going high takes the block out of OFF and starts the delay line. Once lock is reported, the driver is switched on for a fixed synchronisation window, and after that window the block declares data ready. The far end reports an alignment error by pulling the link high. The block then drops everything for a long recovery interval and restarts from the locking step, so that alignment is found again. The pin going low always wins over every other event. When the link was active, it also triggers the remote shut-down request. All timing counts parallel-clock cycles. The recovery interval is a parameter, so tests can use a short value.

Top module: `link_pwr_seq`

## Requirements
- R1: While reset is held and just after it is released, the block is OFF and every output (dllRun, txEnable, dataReady, remoteOffReq) is low.
- R2: pinEn low at a clock edge while in LOCKING, SYNC, RUN or ERR_WAIT puts the block in OFF at that edge, so dllRun, txEnable and dataReady read low in the following cycle.
- R3: Leaving LOCKING, SYNC or RUN because pinEn is low raises remoteOffReq from the first OFF cycle for exactly PULSE_CYCLES cycles. Reset and the other transitions into OFF raise no request.
- R4: pinEn high in OFF moves the block to LOCKING at the next edge. In LOCKING, dllRun is high and txEnable is low.
- R5: dllLocked high at an edge in LOCKING (with pinEn high) moves the block to SYNC. In SYNC, txEnable and dllRun are high and dataReady is low.
- R6: SYNC lasts exactly SYNC_CYCLES cycles and is followed by RUN. dataReady is high only in RUN.
- R7: linkHighRaw passes through two synchronising flops. A level that is high from one edge onward moves SYNC or RUN to ERR_WAIT at the third edge.
- R8: ERR_WAIT holds every output low for exactly ERR_CYCLES cycles and then enters LOCKING if pinEn is high.
- R9: The link-high detect has no effect in OFF and in LOCKING.
- R10: pinEn low during ERR_WAIT goes to OFF with no remote request. From there, pinEn high reaches LOCKING after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinEn | input | 1 | Power-down pin, low requests power-down |
| dllLocked | input | 1 | Delay line reports lock |
| linkHighRaw | input | 1 | Unsynchronised detect of the link pulled high |
| dllRun | output | 1 | Delay line run enable |
| txEnable | output | 1 | Serial driver enable |
| remoteOffReq | output | 1 | Timed request to shut the far receiver down |
| dataReady | output | 1 | Parallel input data may be accepted |

## Verification
A directed walk takes the block through every state in order. The detect is pulsed in OFF and in LOCKING, where it must be ignored, and again in RUN and SYNC, where it must cause recovery. That separates correct state gating from a detect that acts everywhere. The exact cycle counts of the synchronisation window, the recovery interval and the remote request expose off-by-one errors. Entering OFF from recovery, and from an active state, shows whether the remote request is tied to the right transitions. Random runs of the pin, lock and detect then mix preemptions at arbitrary points inside the windows. A cycle-level reference model built from the requirements checks every output on every cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_LOCK = 3'd1,
    ST_SYNC = 3'd2,
    ST_RUN  = 3'd3,
    ST_ERR  = 3'd4
  } pwrState_t;

  typedef struct packed {
    logic cntClear;   // restart the window counter (state change)
    logic pulseFire;  // start the remote shut-down request
  } ctrlStrobe_t;
endpackage

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int SYNC_CYCLES  = 11264,
  parameter int ERR_CYCLES   = 20000000,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        linkHighRaw,
  output logic        syncDone,
  output logic        errDone,
  output logic        linkHigh,
  output logic        pulseActive
);
  localparam int CNT_MAX = (SYNC_CYCLES > ERR_CYCLES) ? SYNC_CYCLES : ERR_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int PW      = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(CNT_MAX);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYCLES - 1);
  localparam logic [CW-1:0] ERR_LAST  = CW'(ERR_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LEN = PW'(PULSE_CYCLES);

  logic [CW-1:0]          winCnt;
  logic [PW-1:0]          pulseCnt;
  logic [SYNC_STAGES-1:0] linkSync;

  // window counter: zero on the first cycle of each state, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winCnt <= '0;
    else if (strobe.cntClear)  winCnt <= '0;
    else if (winCnt != CNT_TOP) winCnt <= winCnt + 1'b1;
  end

  assign syncDone = (winCnt == SYNC_LAST);
  assign errDone  = (winCnt == ERR_LAST);

  // remote shut-down request length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobe.pulseFire) pulseCnt <= PULSE_LEN;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseActive = (pulseCnt != '0);

  // link-high detect synchroniser
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) linkSync <= '0;
        else       linkSync <= linkHighRaw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) linkSync <= '0;
        else       linkSync <= {linkSync[SYNC_STAGES-2:0], linkHighRaw};
      end
    end
  endgenerate

  assign linkHigh = linkSync[SYNC_STAGES-1];

  AST_PULSE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pulseFire |=> pulseActive); // R3

  AST_LINK_TWO_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkHigh) |-> $past(linkHighRaw, 2)); // R7
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinEn,
  input  logic        dllLocked,
  input  logic        linkHigh,
  input  logic        syncDone,
  input  logic        errDone,
  output pwrState_t   state,
  output ctrlStrobe_t strobe
);
  pwrState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:  if (pinEn) nextState = ST_LOCK;
      ST_LOCK: begin
        if (!pinEn)         nextState = ST_OFF;
        else if (dllLocked) nextState = ST_SYNC;
      end
      ST_SYNC: begin
        if (!pinEn)        nextState = ST_OFF;
        else if (linkHigh) nextState = ST_ERR;
        else if (syncDone) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (!pinEn)        nextState = ST_OFF;
        else if (linkHigh) nextState = ST_ERR;
      end
      ST_ERR: begin
        if (!pinEn)       nextState = ST_OFF;
        else if (errDone) nextState = ST_LOCK;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_comb begin
    strobe.cntClear  = (nextState != state);
    strobe.pulseFire = !pinEn &&
      (state == ST_LOCK || state == ST_SYNC || state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  AST_PIN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!pinEn && state != ST_OFF) |=> state == ST_OFF); // R2

  AST_LOCK_TO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && pinEn && dllLocked) |=> state == ST_SYNC); // R5

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !pinEn) |=> state == ST_OFF); // R9

  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC && pinEn && !linkHigh && !syncDone) |=> state == ST_SYNC); // R6
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
  import lps_pkg::*;
#(
  parameter int SYNC_CYCLES  = 11264,
  parameter int ERR_CYCLES   = 20000000,
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinEn,
  input  logic dllLocked,
  input  logic linkHighRaw,
  output logic dllRun,
  output logic txEnable,
  output logic remoteOffReq,
  output logic dataReady
);
  pwrState_t   state;
  ctrlStrobe_t strobe;
  logic        syncDone, errDone, linkHigh, pulseActive;

  lps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinEn(pinEn), .dllLocked(dllLocked),
    .linkHigh(linkHigh), .syncDone(syncDone), .errDone(errDone),
    .state(state), .strobe(strobe)
  );

  lps_datapath #(
    .SYNC_CYCLES(SYNC_CYCLES), .ERR_CYCLES(ERR_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkHighRaw(linkHighRaw),
    .syncDone(syncDone), .errDone(errDone), .linkHigh(linkHigh),
    .pulseActive(pulseActive)
  );

  assign dllRun       = (state == ST_LOCK) || (state == ST_SYNC) || (state == ST_RUN);
  assign txEnable     = (state == ST_SYNC) || (state == ST_RUN);
  assign dataReady    = (state == ST_RUN);
  assign remoteOffReq = pulseActive;

  AST_RUN_TO_OFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !pinEn) |=> (remoteOffReq && !txEnable)); // R3

  AST_READY_NEEDS_TX: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (txEnable && dllRun)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !(dllRun || txEnable || remoteOffReq || dataReady)); // R1
endmodule

// File: tb/sim_link_pwr_seq.sv
module sim_link_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N  = 40;
  localparam int ERR_N   = 30;
  localparam int PULSE_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinEn = 1'b0, dllLocked = 1'b0, linkHighRaw = 1'b0;
  logic dllRun, txEnable, remoteOffReq, dataReady;

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pwr_seq #(.SYNC_CYCLES(SYNC_N), .ERR_CYCLES(ERR_N), .PULSE_CYCLES(PULSE_N)) u0 (
    .clk(clk), .rstN(rstN), .pinEn(pinEn), .dllLocked(dllLocked),
    .linkHighRaw(linkHighRaw), .dllRun(dllRun), .txEnable(txEnable),
    .remoteOffReq(remoteOffReq), .dataReady(dataReady)
  );

  // reference model written from the requirements: 0 OFF,1 LOCK,2 SYNC,3 RUN,4 ERR
  int mState = 0, mCnt = 0, mPulse = 0;
  bit mS1 = 0, mS2 = 0;

  function automatic bit expRun(int s);   return s == 1 || s == 2 || s == 3; endfunction
  function automatic bit expTx(int s);    return s == 2 || s == 3; endfunction
  function automatic bit expReady(int s); return s == 3; endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mPulse = 0; mS1 = 0; mS2 = 0;
    end else begin
      int nxt;
      nxt = mState;
      case (mState)
        0: if (pinEn) nxt = 1;
        1: if (!pinEn) nxt = 0; else if (dllLocked) nxt = 2;
        2: if (!pinEn) nxt = 0; else if (mS2) nxt = 4; else if (mCnt == SYNC_N-1) nxt = 3;
        3: if (!pinEn) nxt = 0; else if (mS2) nxt = 4;
        default: if (!pinEn) nxt = 0; else if (mCnt == ERR_N-1) nxt = 1;
      endcase
      if (!pinEn && (mState == 1 || mState == 2 || mState == 3)) mPulse = PULSE_N;
      else if (mPulse != 0) mPulse = mPulse - 1;
      if (nxt != mState) mCnt = 0; else mCnt = mCnt + 1;
      mState = nxt;
      mS2 = mS1; mS1 = linkHighRaw;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    chk("R4 model dllRun", dllRun, expRun(mState));
    chk("R5 model txEnable", txEnable, expTx(mState));
    chk("R6 model dataReady", dataReady, expReady(mState));
    chk("R3 model remoteOffReq", remoteOffReq, mPulse != 0);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic allLow(string tag);
    chk(tag, dllRun, 1'b0); chk(tag, txEnable, 1'b0);
    chk(tag, dataReady, 1'b0); chk(tag, remoteOffReq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    step(3);
    allLow("R1 in reset");
    rstN = 1'b1;
    step(1);
    allLow("R1 after reset");
    cmpOn = 1'b1;

    // R9: detect ignored in OFF
    linkHighRaw = 1'b1; step(5);
    allLow("R9 detect in OFF");
    linkHighRaw = 1'b0; step(3);

    // R4: power up
    pinEn = 1'b1; step(1);
    chk("R4 dllRun in LOCKING", dllRun, 1'b1);
    chk("R4 txEnable in LOCKING", txEnable, 1'b0);
    // R9: detect ignored in LOCKING
    linkHighRaw = 1'b1; step(5);
    chk("R9 still LOCKING dllRun", dllRun, 1'b1);
    chk("R9 still LOCKING txEnable", txEnable, 1'b0);
    linkHighRaw = 1'b0; step(3);

    // R5 / R6
    dllLocked = 1'b1; step(1);
    chk("R5 txEnable in SYNC", txEnable, 1'b1);
    chk("R5 dataReady low in SYNC", dataReady, 1'b0);
    step(SYNC_N - 1);
    chk("R6 last SYNC cycle", dataReady, 1'b0);
    step(1);
    chk("R6 RUN after window", dataReady, 1'b1);

    // R7 / R8
    linkHighRaw = 1'b1; step(2);
    chk("R7 two flops delay", dataReady, 1'b1);
    step(1);
    chk("R7 ERR_WAIT tx", txEnable, 1'b0);
    chk("R8 ERR_WAIT dllRun", dllRun, 1'b0);
    linkHighRaw = 1'b0;
    step(ERR_N - 1);
    chk("R8 last ERR_WAIT cycle", dllRun, 1'b0);
    step(1);
    chk("R8 back to LOCKING", dllRun, 1'b1);
    step(1);
    chk("R5 relock to SYNC", txEnable, 1'b1);
    step(SYNC_N);
    chk("R6 RUN again", dataReady, 1'b1);

    // R2 / R3
    pinEn = 1'b0; step(1);
    chk("R2 tx off", txEnable, 1'b0);
    chk("R2 dllRun off", dllRun, 1'b0);
    chk("R3 request start", remoteOffReq, 1'b1);
    step(PULSE_N - 1);
    chk("R3 request last cycle", remoteOffReq, 1'b1);
    step(1);
    chk("R3 request ends", remoteOffReq, 1'b0);

    // R10: power-down from ERR_WAIT
    pinEn = 1'b1; step(2);
    chk("R10 SYNC reached", txEnable, 1'b1);
    linkHighRaw = 1'b1; step(3);
    chk("R10 ERR_WAIT entered", dllRun, 1'b0);
    linkHighRaw = 1'b0; step(2);
    pinEn = 1'b0; step(1);
    chk("R10 no request", remoteOffReq, 1'b0);
    pinEn = 1'b1; step(1);
    chk("R10 LOCKING after one edge", dllRun, 1'b1);

    // random phase
    for (int i = 0; i < 8000; i++) begin
      if (!pinEn) begin if ($urandom_range(19) == 0) pinEn = 1'b1; end
      else if ($urandom_range(399) == 0) pinEn = 1'b0;
      if (!dllLocked) begin if ($urandom_range(5) == 0) dllLocked = 1'b1; end
      else if ($urandom_range(299) == 0) dllLocked = 1'b0;
      linkHighRaw = ($urandom_range(149) == 0);
      step(1);
    end

    // directed: reset during activity
    rstN = 1'b0; cmpOn = 1'b0; step(1);
    allLow("R1 reset mid-run");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule